// File: doc/BRIEF.md
# Daisy-Chained Converter Readout Sequencer

This block is the host side of a serial chain of N 16-bit converters that share one convert strobe and one serial clock. On a start request it raises the convert strobe to begin a conversion in every device. It then waits for the conversion-complete indication that the far end of the chain returns. That indication is passed through a synchronizer, and the block then holds off for a fixed settling time so that every device in the chain has finished. After that it drops the convert strobe and produces the serial clock bursts that move the whole chain out through the nearest device.

The stream carries one status bit, then one 16-bit word per device. The status bit comes out on the first falling edge and is thrown away. The nearest device's word follows, most significant bit first, and then the word of each device further up the chain. The block samples the data line on each serial clock rise. When the stream is complete, it presents all N words together with a one-cycle valid strobe and returns to idle. If the completion indication never arrives, a timeout ends the conversion with a one-cycle error pulse.

Top module: `chain_adc_reader`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `cnvst_o` is 0, `sclk_o` is 1, `valid_o` is 0 and `timeout_o` is 0.
- R2: A `start_i` sampled high while idle drives `cnvst_o` high from the next clock edge. A `start_i` that arrives during a conversion or a readout is ignored: it produces no extra valid pulse and no new conversion.
- R3: `cnvst_o` stays high after `conv_done_i` rises until the synchronizer has passed the indication and the settling delay has elapsed. The settling delay is at least SETTLE_NS rounded up to whole clock cycles, so the gap is never shorter than 3 cycles with the default settings.
- R4: Each readout produces exactly 16*N_DEV+1 falling edges on `sclk_o`, all while `cnvst_o` is low. `sclk_o` is high whenever `cnvst_o` is high.
- R5: During readout every low phase and every high phase of `sclk_o` between two falls lasts exactly DIV_HALF clock cycles.
- R6: The bit sampled after the first fall is discarded. The next 16 bits, MSB first, form the nearest device's word on `words_o[15:0]`. Device k (k = 0 nearest) appears on `words_o[16k+15:16k]`.
- R7: `valid_o` is high for exactly one cycle after the last rising edge of the readout. A `start_i` in the cycle after that pulse begins a new conversion.
- R8: If `conv_done_i` is not seen within TIMEOUT_CYC cycles, `cnvst_o` stays high for exactly TIMEOUT_CYC cycles and then falls. `timeout_o` is high for one cycle, starting at the same edge. No serial clock and no valid pulse follow.
- R9: `words_o` changes only together with a `valid_o` pulse. A timed-out conversion leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request one conversion and readout |
| conv_done_i | input | 1 | Conversion-complete indication from the far end of the chain, asynchronous |
| sdata_i | input | 1 | Serial data from the nearest device |
| cnvst_o | output | 1 | Convert strobe to all devices |
| sclk_o | output | 1 | Serial clock to all devices, idles high |
| words_o | output | 16*N_DEV | Captured words, device 0 in the low bits |
| valid_o | output | 1 | One-cycle strobe when `words_o` is updated |
| timeout_o | output | 1 | One-cycle pulse when a conversion times out |

## Verification
The bench models the chain as a bit stream that starts with a status bit of 1. If the block kept the status bit, every word would shift by one place and the last bit of the far word would be lost. If it produced one edge too few or too many, the far word's LSB would go missing or the edge-count check would trip. The bench also measures the gap from the completion indication to the fall of the convert strobe, and the width of each serial clock phase, against the settling and divider parameters. Start requests injected mid-transaction would show up as a second valid pulse or a restarted strobe. The timeout case checks the strobe length to the cycle and confirms that the held words survive.

// File: rtl/chain_adc_pkg.sv
package chain_adc_pkg;

    localparam int unsigned WORD_W = 16;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_CONV,
        PH_SETTLE,
        PH_READ,
        PH_DONE
    } phase_e;

    function automatic int unsigned ns_to_cycles(input int unsigned ns,
                                                 input int unsigned clk_ns);
        int unsigned c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/cadc_sync.sv
module cadc_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[i] <= 1'b0;
                    else     chain_q[i] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[i] <= 1'b0;
                    else     chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/cadc_sclk_gen.sv
module cadc_sclk_gen #(
    parameter int unsigned DIV_HALF = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic sclk_o,
    output logic rise_o
);
    localparam int unsigned CW = $clog2(DIV_HALF + 1);
    localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);

    logic [CW-1:0] cnt_q;
    logic          sclk_q;
    logic          wrap;

    assign wrap   = en && (cnt_q == LAST);
    assign rise_o = wrap && !sclk_q;
    assign sclk_o = sclk_q;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt_q  <= '0;
            sclk_q <= 1'b1;
        end else if (wrap) begin
            cnt_q  <= '0;
            sclk_q <= ~sclk_q;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/cadc_deser.sv
module cadc_deser #(
    parameter int unsigned N_DEV = 2
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic                                   clr,
    input  logic                                   sample,
    input  logic                                   din,
    output logic [chain_adc_pkg::WORD_W*N_DEV-1:0] bits_o,
    output logic                                   last_o
);
    import chain_adc_pkg::*;

    localparam int unsigned DW    = WORD_W * N_DEV;
    localparam int unsigned TOTAL = DW + 1;
    localparam int unsigned RW    = $clog2(TOTAL + 1);
    localparam logic [RW-1:0] LAST = RW'(TOTAL - 1);

    logic [RW-1:0] rcnt_q;
    logic [DW-1:0] shreg_q;

    assign last_o = sample && (rcnt_q == LAST);
    assign bits_o = shreg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rcnt_q  <= '0;
            shreg_q <= '0;
        end else if (clr) begin
            rcnt_q  <= '0;
        end else if (sample) begin
            rcnt_q <= rcnt_q + 1'b1;
            if (rcnt_q != '0)
                shreg_q <= {shreg_q[DW-2:0], din};
        end
    end
endmodule

// File: rtl/cadc_phase_fsm.sv
module cadc_phase_fsm #(
    parameter int unsigned TIMEOUT_CYC = 1000,
    parameter int unsigned SETTLE_CYC  = 3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic                  done_sync,
    input  logic                  last_rise,
    output chain_adc_pkg::phase_e phase_o,
    output logic                  cnvst_o,
    output logic                  timeout_o
);
    import chain_adc_pkg::*;

    localparam int unsigned TW = $clog2(max_u(TIMEOUT_CYC, SETTLE_CYC) + 1);
    localparam logic [TW-1:0] T_LAST = TW'(TIMEOUT_CYC - 1);
    localparam logic [TW-1:0] S_LAST = TW'(SETTLE_CYC - 1);

    phase_e        phase_q;
    logic [TW-1:0] tmr_q;
    logic          cnvst_q;
    logic          tout_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            tmr_q   <= '0;
            cnvst_q <= 1'b0;
            tout_q  <= 1'b0;
        end else begin
            tout_q <= 1'b0;
            case (phase_q)
                PH_IDLE: begin
                    if (start) begin
                        phase_q <= PH_CONV;
                        tmr_q   <= '0;
                        cnvst_q <= 1'b1;
                    end
                end
                PH_CONV: begin
                    if (done_sync) begin
                        phase_q <= PH_SETTLE;
                        tmr_q   <= '0;
                    end else if (tmr_q == T_LAST) begin
                        phase_q <= PH_IDLE;
                        cnvst_q <= 1'b0;
                        tout_q  <= 1'b1;
                    end else begin
                        tmr_q <= tmr_q + 1'b1;
                    end
                end
                PH_SETTLE: begin
                    if (tmr_q == S_LAST) begin
                        phase_q <= PH_READ;
                        cnvst_q <= 1'b0;
                    end else begin
                        tmr_q <= tmr_q + 1'b1;
                    end
                end
                PH_READ: begin
                    if (last_rise) phase_q <= PH_DONE;
                end
                PH_DONE: phase_q <= PH_IDLE;
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign phase_o   = phase_q;
    assign cnvst_o   = cnvst_q;
    assign timeout_o = tout_q;
endmodule

// File: rtl/chain_adc_reader.sv
module chain_adc_reader #(
    parameter int unsigned N_DEV         = 2,
    parameter int unsigned DIV_HALF      = 2,
    parameter int unsigned CLK_PERIOD_NS = 20,
    parameter int unsigned SETTLE_NS     = 50,
    parameter int unsigned TIMEOUT_CYC   = 1000,
    parameter int unsigned SYNC_STAGES   = 2
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic                                   start_i,
    input  logic                                   conv_done_i,
    input  logic                                   sdata_i,
    output logic                                   cnvst_o,
    output logic                                   sclk_o,
    output logic [chain_adc_pkg::WORD_W*N_DEV-1:0] words_o,
    output logic                                   valid_o,
    output logic                                   timeout_o
);
    import chain_adc_pkg::*;

    localparam int unsigned DW         = WORD_W * N_DEV;
    localparam int unsigned SETTLE_CYC = ns_to_cycles(SETTLE_NS, CLK_PERIOD_NS);

    phase_e        phase;
    logic          done_sync;
    logic          rise;
    logic          last_rise;
    logic [DW-1:0] stream_bits;
    logic [DW-1:0] ordered;
    logic [DW-1:0] words_q;
    logic          valid_q;

    cadc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(conv_done_i), .q(done_sync)
    );

    cadc_phase_fsm #(.TIMEOUT_CYC(TIMEOUT_CYC), .SETTLE_CYC(SETTLE_CYC)) u_fsm (
        .clk(clk), .rst(rst), .start(start_i), .done_sync(done_sync),
        .last_rise(last_rise), .phase_o(phase), .cnvst_o(cnvst_o),
        .timeout_o(timeout_o)
    );

    cadc_sclk_gen #(.DIV_HALF(DIV_HALF)) u_sclk (
        .clk(clk), .rst(rst), .en(phase == PH_READ),
        .sclk_o(sclk_o), .rise_o(rise)
    );

    cadc_deser #(.N_DEV(N_DEV)) u_deser (
        .clk(clk), .rst(rst), .clr(phase != PH_READ), .sample(rise),
        .din(sdata_i), .bits_o(stream_bits), .last_o(last_rise)
    );

    // first-arriving word sits in the top slice; move it to slot 0
    generate
        for (genvar k = 0; k < N_DEV; k++) begin : g_map
            assign ordered[k*WORD_W +: WORD_W] = stream_bits[(N_DEV-1-k)*WORD_W +: WORD_W];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            words_q <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= (phase == PH_DONE);
            if (phase == PH_DONE) words_q <= ordered;
        end
    end

    assign words_o = words_q;
    assign valid_o = valid_q;
endmodule

// File: rtl/chain_adc_reader_chk.sv
module chain_adc_reader_chk #(
    parameter int unsigned N_DEV    = 2,
    parameter int unsigned DIV_HALF = 2
) (
    input logic                                   clk,
    input logic                                   rst,
    input logic                                   cnvst_o,
    input logic                                   sclk_o,
    input logic                                   valid_o,
    input logic                                   timeout_o,
    input logic [chain_adc_pkg::WORD_W*N_DEV-1:0] words_o
);
    localparam int unsigned EDGES = chain_adc_pkg::WORD_W * N_DEV + 1;

    int unsigned low_run;
    int unsigned fall_cnt;
    logic        sclk_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_run  <= 0;
            fall_cnt <= 0;
            sclk_d   <= 1'b1;
        end else begin
            sclk_d  <= sclk_o;
            low_run <= sclk_o ? 0 : low_run + 1;
            if (cnvst_o)                fall_cnt <= 0;
            else if (sclk_d && !sclk_o) fall_cnt <= fall_cnt + 1;
        end
    end

    AST_VALID_SINGLE:  assert property (@(posedge clk) disable iff (rst) valid_o |=> !valid_o); // R7
    AST_EDGE_TOTAL:    assert property (@(posedge clk) disable iff (rst) valid_o |-> fall_cnt == EDGES); // R4
    AST_SCLK_PARKED:   assert property (@(posedge clk) disable iff (rst) cnvst_o |-> sclk_o); // R4
    AST_LOW_WIDTH:     assert property (@(posedge clk) disable iff (rst) $rose(sclk_o) |-> low_run == DIV_HALF); // R5
    AST_TOUT_PULSE:    assert property (@(posedge clk) disable iff (rst) timeout_o |-> !cnvst_o && !valid_o); // R8
    AST_TOUT_ONE:      assert property (@(posedge clk) disable iff (rst) timeout_o |=> !timeout_o); // R8
    AST_CNVST_MIN:     assert property (@(posedge clk) disable iff (rst) $rose(cnvst_o) |=> cnvst_o); // R2
    AST_WORDS_HELD:    assert property (@(posedge clk) disable iff (rst) !valid_o |-> $stable(words_o)); // R9
endmodule

bind chain_adc_reader chain_adc_reader_chk #(.N_DEV(N_DEV), .DIV_HALF(DIV_HALF)) chk_i (
    .clk(clk), .rst(rst), .cnvst_o(cnvst_o), .sclk_o(sclk_o),
    .valid_o(valid_o), .timeout_o(timeout_o), .words_o(words_o)
);

// File: tb/chain_adc_reader_tb_top.sv
`timescale 1ns/1ps
module chain_adc_reader_tb_top;
    localparam int N_DEV    = 2;
    localparam int DIV_HALF = 2;
    localparam int TOUT     = 40;
    localparam int DW       = 16 * N_DEV;
    localparam int SLEN     = DW + 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0;
    logic conv_done_i = 1'b0;
    logic sdata_i = 1'b0;
    logic cnvst_o, sclk_o, valid_o, timeout_o;
    logic [DW-1:0] words_o;

    always #10 clk = ~clk;

    chain_adc_reader #(.N_DEV(N_DEV), .DIV_HALF(DIV_HALF), .CLK_PERIOD_NS(20),
                       .SETTLE_NS(50), .TIMEOUT_CYC(TOUT), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .conv_done_i(conv_done_i),
        .sdata_i(sdata_i), .cnvst_o(cnvst_o), .sclk_o(sclk_o), .words_o(words_o),
        .valid_o(valid_o), .timeout_o(timeout_o)
    );

    int nchk = 0;
    int nerr = 0;
    int cyc  = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // chain model: stream[0] is the status bit, then device words MSB first
    logic stream [SLEN];
    int   sidx = 0;
    always @(posedge cnvst_o) sidx = 0;
    always @(negedge sclk_o) begin
        if (sidx < SLEN) sdata_i = stream[sidx];
        sidx++;
    end

    // port monitors, sampled away from the active edge
    int falls = 0, bad_cnv = 0, bad_run = 0, vcount = 0, tcount = 0;
    int lowrun = 0, highrun = 0;
    bit seen_fall = 0;
    logic prev_sclk = 1'b1;
    always @(posedge clk) cyc++;
    always @(negedge clk) begin
        if (!rst) begin
            if (prev_sclk && !sclk_o) begin
                falls++;
                if (cnvst_o) bad_cnv++;
                if (seen_fall && highrun != DIV_HALF) bad_run++;
                seen_fall = 1;
                highrun = 0;
            end
            if (!sclk_o) lowrun++;
            else begin
                if (!prev_sclk && lowrun != DIV_HALF) bad_run++;
                lowrun = 0;
                if (seen_fall) highrun++;
            end
            if (cnvst_o) seen_fall = 0;
            if (valid_o) vcount++;
            if (timeout_o) tcount++;
            prev_sclk = sclk_o;
        end
    end

    task automatic clear_mon();
        falls = 0; bad_cnv = 0; bad_run = 0; vcount = 0; tcount = 0;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk(cnvst_o == 1'b0 && sclk_o == 1'b1, "R1 strobes in reset", {cnvst_o, sclk_o}, 2'b01);
        chk(valid_o == 1'b0 && timeout_o == 1'b0, "R1 flags in reset", {valid_o, timeout_o}, 2'b00);
        rst = 1'b0;
        @(negedge clk);
        chk(cnvst_o == 1'b0 && sclk_o == 1'b1, "R1 strobes after reset", {cnvst_o, sclk_o}, 2'b01);
        chk(valid_o == 1'b0 && timeout_o == 1'b0, "R1 flags after reset", {valid_o, timeout_o}, 2'b00);
    endtask

    task automatic t_read(input logic [DW-1:0] pat, input bit poke, input string tag);
        int t0, dly;
        stream[0] = 1'b1;
        for (int k = 0; k < N_DEV; k++)
            for (int b = 0; b < 16; b++)
                stream[1 + 16*k + b] = pat[16*k + 15 - b];
        clear_mon();
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(cnvst_o == 1'b1, {"R2 strobe raised ", tag}, cnvst_o, 1);
        repeat (4) @(negedge clk);
        if (poke) begin
            start_i = 1'b1; @(negedge clk); start_i = 1'b0;
        end
        t0 = cyc;
        conv_done_i = 1'b1;
        while (cnvst_o) @(negedge clk);
        dly = cyc - t0;
        conv_done_i = 1'b0;
        chk(dly >= 3, {"R3 settle gap ", tag}, dly, 3);
        if (poke) begin
            repeat (6) @(negedge clk);
            start_i = 1'b1; @(negedge clk); start_i = 1'b0;
        end
        while (!valid_o) @(negedge clk);
        for (int k = 0; k < N_DEV; k++)
            chk(words_o[16*k +: 16] == pat[16*k +: 16], {"R6 word ", tag},
                words_o[16*k +: 16], pat[16*k +: 16]);
        chk(falls == SLEN && bad_cnv == 0, {"R4 edge count ", tag}, falls, SLEN);
        chk(bad_run == 0, {"R5 clock phase width ", tag}, bad_run, 0);
        @(negedge clk);
        chk(valid_o == 1'b0, {"R7 valid width ", tag}, valid_o, 0);
        if (poke) begin
            repeat (12) begin
                @(negedge clk);
                chk(cnvst_o == 1'b0, {"R2 stray start ignored ", tag}, cnvst_o, 0);
            end
            chk(vcount == 1, {"R2 single valid ", tag}, vcount, 1);
        end
    endtask

    task automatic t_timeout();
        logic [DW-1:0] held;
        int n;
        held = words_o;
        clear_mon();
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        n = 0;
        while (cnvst_o) begin n++; @(negedge clk); end
        chk(n == TOUT, "R8 strobe length on timeout", n, TOUT);
        chk(timeout_o == 1'b1, "R8 timeout pulse", timeout_o, 1);
        @(negedge clk);
        chk(timeout_o == 1'b0, "R8 timeout width", timeout_o, 0);
        repeat (10) @(negedge clk);
        chk(falls == 0 && vcount == 0, "R8 no readout after timeout", {falls[31:0], vcount[31:0]}, 0);
        chk(words_o == held, "R9 words held across timeout", words_o, held);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL watchdog expired actual=%0d expected=done", cyc);
        finish_run();
    end

    initial begin
        t_reset();
        @(negedge clk);
        t_read({16'h0F1E, 16'hA5C3}, 1'b0, "mixed");
        t_read({16'h7FFE, 16'h8001}, 1'b0, "edges back-to-back R7");
        t_read({16'hFFFF, 16'h0000}, 1'b1, "poked");
        t_timeout();
        t_read({16'h1234, 16'hFEDC}, 1'b0, "after timeout");
        finish_run();
    end
endmodule